// File: doc/BRIEF.md
# Load/Store Data Watchpoint Comparator

This block watches the processor's load/store bus and raises a watchpoint event when an access satisfies programmed conditions on its address and on the data it carries. There are two address comparators and two data comparators. Each one compares unsigned against its own 32-bit reference value using one of four relations: equal, not equal, greater than or less than. Every enabled comparator must agree for an event to fire, so two comparators of the same kind can describe an open range, such as "above A and below B".

Address comparison drops low address bits according to the size of the access. A data comparator can work on the whole word, on half-word lanes or on byte lanes, and it has a per-byte exclusion mask. This lets a byte or half-word variable be caught even when software reaches it through a wider load or store. Configuration is written through a simple register port. The block produces a registered one-cycle event pulse and a hit flag for each comparator.

Top module: `ldst_watch`

## Requirements
- R1: Before an address comparison, both the access address and the reference have bits [1:0] cleared for a word access (acc_size 2 or 3) and bit [0] cleared for a half-word access (acc_size 1). A byte access (acc_size 0) compares all bits.
- R2: Control field mode (bits [1:0]) selects the relation of the access value to the reference: 0 equal, 1 not equal, 2 greater than, 3 less than. All comparisons are unsigned.
- R3: Control field bmask (bits [7:4]) excludes byte lanes. Bit 3 excludes data[31:24] (lane 0, the lowest byte address) and bit 0 excludes data[7:0] (lane 3). Excluded bytes take no part in any comparison.
- R4: In byte mode (control bits [3:2] = 2), the data condition is true when at least one byte lane is unmasked, transferred and satisfies the relation. A byte access at address offset k transfers lane k. A half-word access transfers lanes 0-1 when address bit 1 is 0 and lanes 2-3 otherwise. A word access transfers all four lanes.
- R5: In half-word mode (control bits [3:2] = 1), half-word lane data[31:16] or data[15:0] takes part only if both of its bytes are transferred and at least one of them is unmasked. Its masked byte is zero in both operands. The condition is true when any participating half-word satisfies the relation. A byte access therefore never satisfies it.
- R6: In word mode (control bits [3:2] = 0, and 3 acts the same), the masked access word is compared with the masked reference word.
- R7: Control bit 8 enables a comparator. A disabled comparator is treated as satisfied and its hit flag stays 0. With no comparator enabled, no event fires.
- R8: event_o is high for exactly the one cycle after an acc_valid cycle in which every enabled comparator is satisfied. Each hit flag is high in that same following cycle when its comparator is enabled and satisfied. All outputs are 0 in any cycle not preceded by a valid access.
- R9: Config register address {kind, index, sel}: kind 0 selects address comparators and kind 1 data comparators, index selects the comparator, sel 0 is the 32-bit reference and sel 1 the control word. A write is effective for an access in the next cycle. After reset every register is 0, so all comparators start disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Load/store access present this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_size | input | 2 | Access size: 0 byte, 1 half-word, 2 or 3 word |
| acc_data | input | 32 | Access data on its big-endian byte lanes |
| cfg_we | input | 1 | Config register write strobe |
| cfg_addr | input | 3 | Config register address {kind, index, sel} |
| cfg_wdata | input | 32 | Config write data |
| event_o | output | 1 | Watchpoint event pulse |
| addr_hit_o | output | 2 | Per address comparator hit flags |
| data_hit_o | output | 2 | Per data comparator hit flags |

## Verification
The hardest condition to reach from the ports is a sub-word lane hiding inside a wider access. The lane that must match carries a value in range, while a masked or untransferred neighbour carries a value that would also match if it were wrongly compared. The stimulus programs the byte-mode and half-word-mode range scenarios and then sends the same variable through byte, half-word and word accesses at aligned and unaligned offsets. It places decoy values in the other lanes, so that only correct lane selection and masking give the expected event pattern.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {CMP_EQ = 2'd0, CMP_NE = 2'd1, CMP_GT = 2'd2, CMP_LT = 2'd3} cmp_mode_e;
  typedef enum logic [1:0] {LM_WORD = 2'd0, LM_HALF = 2'd1, LM_BYTE = 2'd2, LM_RSVD = 2'd3} lane_mode_e;
  typedef enum logic [1:0] {ACC_BYTE = 2'd0, ACC_HALF = 2'd1, ACC_WORD = 2'd2, ACC_WORD2 = 2'd3} acc_size_e;

  typedef struct packed {
    logic       en;
    logic [3:0] bmask;
    lane_mode_e lmode;
    cmp_mode_e  mode;
  } cmp_ctrl_t;

  // unsigned relation of access value a against reference b
  function automatic logic cmp_apply(input logic [31:0] a, input logic [31:0] b, input cmp_mode_e m);
    case (m)
      CMP_EQ:  return a == b;
      CMP_NE:  return a != b;
      CMP_GT:  return a > b;
      default: return a < b;
    endcase
  endfunction

  // address bits kept for comparison at a given access size
  function automatic logic [31:0] addr_keep(input logic [1:0] size);
    case (size)
      2'd0:    return 32'hFFFF_FFFF;
      2'd1:    return 32'hFFFF_FFFE;
      default: return 32'hFFFF_FFFC;
    endcase
  endfunction

  // transferred byte positions, bit p = data[8p+7:8p]
  function automatic logic [3:0] xfer_pos(input logic [1:0] size, input logic [1:0] lo);
    case (size)
      2'd0:    return 4'b1000 >> lo;
      2'd1:    return lo[1] ? 4'b0011 : 4'b1100;
      default: return 4'b1111;
    endcase
  endfunction

  // bit mask of bytes that are not excluded
  function automatic logic [31:0] byte_keep(input logic [3:0] bmask);
    logic [31:0] k;
    for (int p = 0; p < 4; p++) k[8*p +: 8] = {8{~bmask[p]}};
    return k;
  endfunction
endpackage

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs
  import wp_pkg::*;
#(
  parameter int N    = 2,
  parameter int IW   = 1,
  parameter int W    = 32,
  parameter int CAW  = 3,
  parameter bit KIND = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CAW-1:0]  cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [W-1:0]    ref_o  [N],
  output cmp_ctrl_t       ctrl_o [N]
);
  logic sel_kind;
  logic unused_wdata;
  assign sel_kind     = cfg_we && (cfg_addr[CAW-1] == KIND);
  assign unused_wdata = ^cfg_wdata[31:9];

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic hit_idx;
    assign hit_idx = sel_kind && (cfg_addr[CAW-2:1] == IW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ref_o[i]  <= '0;
        ctrl_o[i] <= '0;
      end else if (hit_idx) begin
        if (cfg_addr[0]) ctrl_o[i] <= cmp_ctrl_t'(cfg_wdata[8:0]);
        else             ref_o[i]  <= cfg_wdata[W-1:0];
      end
    end
  end
endmodule

// File: rtl/wp_addr_cmp.sv
module wp_addr_cmp
  import wp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic [AW-1:0] ref_v,
  input  cmp_mode_e     mode,
  output logic          cond
);
  logic [31:0] keep;
  assign keep = addr_keep(size);
  assign cond = cmp_apply(32'(addr) & keep, 32'(ref_v) & keep, mode);
endmodule

// File: rtl/wp_data_cmp.sv
module wp_data_cmp
  import wp_pkg::*;
(
  input  logic [31:0] data,
  input  logic [3:0]  xfer,
  input  logic [31:0] ref_v,
  input  cmp_ctrl_t   ctrl,
  output logic        cond
);
  logic [31:0] keep, dk, rk;
  assign keep = byte_keep(ctrl.bmask);
  assign dk   = data & keep;
  assign rk   = ref_v & keep;

  always_comb begin
    cond = 1'b0;
    case (ctrl.lmode)
      LM_HALF: begin
        for (int h = 0; h < 2; h++) begin
          if (xfer[2*h] && xfer[2*h+1] && !(ctrl.bmask[2*h] && ctrl.bmask[2*h+1]))
            cond = cond | cmp_apply({16'h0, dk[16*h +: 16]}, {16'h0, rk[16*h +: 16]}, ctrl.mode);
        end
      end
      LM_BYTE: begin
        for (int p = 0; p < 4; p++) begin
          if (xfer[p] && !ctrl.bmask[p])
            cond = cond | cmp_apply({24'h0, dk[8*p +: 8]}, {24'h0, rk[8*p +: 8]}, ctrl.mode);
        end
      end
      default: cond = cmp_apply(dk, rk, ctrl.mode);
    endcase
  end
endmodule

// File: rtl/ldst_watch.sv
module ldst_watch
  import wp_pkg::*;
#(
  parameter int AW     = 32,
  parameter int N_ACMP = 2,
  parameter int N_DCMP = 2,
  localparam int NMAX  = (N_ACMP > N_DCMP) ? N_ACMP : N_DCMP,
  localparam int IW    = (NMAX > 1) ? $clog2(NMAX) : 1,
  localparam int CAW   = IW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [AW-1:0]     acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       acc_data,
  input  logic              cfg_we,
  input  logic [CAW-1:0]    cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              event_o,
  output logic [N_ACMP-1:0] addr_hit_o,
  output logic [N_DCMP-1:0] data_hit_o
);
  logic [AW-1:0] a_ref  [N_ACMP];
  cmp_ctrl_t     a_ctrl [N_ACMP];
  logic [31:0]   d_ref  [N_DCMP];
  cmp_ctrl_t     d_ctrl [N_DCMP];

  // named internal events, observed by the checker
  logic [N_ACMP-1:0] a_en, a_cond;
  logic [N_DCMP-1:0] d_en, d_cond;
  logic [3:0]        xfer;
  logic              any_en, all_ok, ev_d;

  wp_cfg_regs #(.N(N_ACMP), .IW(IW), .W(AW), .CAW(CAW), .KIND(1'b0)) u_acfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ref_o(a_ref), .ctrl_o(a_ctrl));

  wp_cfg_regs #(.N(N_DCMP), .IW(IW), .W(32), .CAW(CAW), .KIND(1'b1)) u_dcfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ref_o(d_ref), .ctrl_o(d_ctrl));

  assign xfer = xfer_pos(acc_size, acc_addr[1:0]);

  for (genvar i = 0; i < N_ACMP; i++) begin : g_acmp
    logic unused_fields;
    assign unused_fields = ^{a_ctrl[i].bmask, a_ctrl[i].lmode};
    assign a_en[i] = a_ctrl[i].en;
    wp_addr_cmp #(.AW(AW)) u_cmp (
      .addr(acc_addr), .size(acc_size), .ref_v(a_ref[i]),
      .mode(a_ctrl[i].mode), .cond(a_cond[i]));
  end

  for (genvar j = 0; j < N_DCMP; j++) begin : g_dcmp
    assign d_en[j] = d_ctrl[j].en;
    wp_data_cmp u_cmp (
      .data(acc_data), .xfer(xfer), .ref_v(d_ref[j]),
      .ctrl(d_ctrl[j]), .cond(d_cond[j]));
  end

  assign any_en = |{a_en, d_en};
  assign all_ok = &{a_cond | ~a_en, d_cond | ~d_en};
  assign ev_d   = acc_valid && any_en && all_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      event_o    <= 1'b0;
      addr_hit_o <= '0;
      data_hit_o <= '0;
    end else begin
      event_o    <= ev_d;
      addr_hit_o <= acc_valid ? (a_cond & a_en) : '0;
      data_hit_o <= acc_valid ? (d_cond & d_en) : '0;
    end
  end
endmodule

// File: rtl/wp_checker.sv
module wp_checker
  import wp_pkg::*;
#(
  parameter int AW     = 32,
  parameter int N_ACMP = 2,
  parameter int N_DCMP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [AW-1:0]     acc_addr,
  input logic [1:0]        acc_size,
  input logic              event_o,
  input logic [N_ACMP-1:0] addr_hit_o,
  input logic [N_DCMP-1:0] data_hit_o,
  input logic [N_ACMP-1:0] a_en,
  input logic [N_DCMP-1:0] d_en,
  input logic [AW-1:0]     a_ref0,
  input cmp_mode_e         a_mode0
);
  assert_pulse_after_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(acc_valid));

  assert_idle_outputs_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_valid) |-> (!event_o && addr_hit_o == '0 && data_hit_o == '0));

  assert_hit_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_hit_o & ~$past(a_en)) == '0) && ((data_hit_o & ~$past(d_en)) == '0));

  assert_event_needs_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> (($past(a_en) != '0) || ($past(d_en) != '0)));

  assert_event_all_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> ((&(addr_hit_o | ~$past(a_en))) && (&(data_hit_o | ~$past(d_en)))));

  assert_word_low_bits_dropped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_size[1] && a_en[0] && a_mode0 == CMP_EQ &&
     acc_addr[AW-1:2] == a_ref0[AW-1:2]) |=> addr_hit_o[0]);
endmodule

bind ldst_watch wp_checker #(.AW(AW), .N_ACMP(N_ACMP), .N_DCMP(N_DCMP)) u_wp_checker (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_size(acc_size), .event_o(event_o), .addr_hit_o(addr_hit_o),
  .data_hit_o(data_hit_o), .a_en(a_en), .d_en(d_en),
  .a_ref0(a_ref[0]), .a_mode0(a_ctrl[0].mode));

// File: tb/tb_ldst_watch.sv
module tb_ldst_watch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_data = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        event_o;
  logic [1:0]  addr_hit_o, data_hit_o;

  int n_tests = 0;
  int n_fail  = 0;

  // bench shadow of the programmed state, indexed {kind, index}
  logic [31:0] sh_ref  [4];
  logic [31:0] sh_ctrl [4];

  logic [4:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_watch dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_data(acc_data), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .event_o(event_o),
    .addr_hit_o(addr_hit_o), .data_hit_o(data_hit_o));

  function automatic bit rel(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m);
    if (m == 2'd0) return a == b;
    if (m == 2'd1) return a != b;
    if (m == 2'd2) return a > b;
    return a < b;
  endfunction

  function automatic int size_bytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit m_addr(input int k, input logic [31:0] a, input logic [1:0] s);
    logic [31:0] drop;
    drop = 32'(size_bytes(s) - 1);
    return rel(a & ~drop, sh_ref[k] & ~drop, sh_ctrl[k][1:0]);
  endfunction

  // lane L: L = 0 is data[31:24], the lowest byte address
  function automatic logic [7:0] lane(input logic [31:0] x, input int L);
    return x[31-8*L -: 8];
  endfunction

  function automatic bit m_data(input int k, input logic [31:0] a, input logic [1:0] s,
                                input logic [31:0] d);
    logic [31:0] rv, dx, rx;
    logic [3:0]  msk;
    logic [1:0]  md, lm;
    int nb, st;
    bit r, mk0, mk1;
    rv = sh_ref[k]; md = sh_ctrl[k][1:0]; lm = sh_ctrl[k][3:2]; msk = sh_ctrl[k][7:4];
    nb = size_bytes(s);
    st = int'(a[1:0]) & ~(nb - 1);
    r = 1'b0;
    if (lm == 2'd1) begin
      for (int h = 0; h < 2; h++) begin
        mk0 = msk[3-2*h]; mk1 = msk[2-2*h];
        if (2*h >= st && 2*h + 1 < st + nb && !(mk0 && mk1))
          r |= rel({16'h0, mk0 ? 8'h0 : lane(d, 2*h), mk1 ? 8'h0 : lane(d, 2*h+1)},
                   {16'h0, mk0 ? 8'h0 : lane(rv, 2*h), mk1 ? 8'h0 : lane(rv, 2*h+1)}, md);
      end
    end else if (lm == 2'd2) begin
      for (int L = 0; L < 4; L++)
        if (L >= st && L < st + nb && !msk[3-L])
          r |= rel({24'h0, lane(d, L)}, {24'h0, lane(rv, L)}, md);
    end else begin
      dx = d; rx = rv;
      for (int L = 0; L < 4; L++)
        if (msk[3-L]) begin dx[31-8*L -: 8] = 8'h0; rx[31-8*L -: 8] = 8'h0; end
      r = rel(dx, rx, md);
    end
    return r;
  endfunction

  task automatic wr(input logic [2:0] ad, input logic [31:0] v);
    @(negedge clk);
    acc_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = v;
    if (ad[0]) sh_ctrl[ad[2:1]] = v; else sh_ref[ad[2:1]] = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: one access, expected outputs pushed to the scoreboard
  task automatic access(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d,
                        input string tag);
    logic [1:0] ah, dh, ae, de;
    bit ev;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = s; acc_data = d;
    for (int i = 0; i < 2; i++) begin
      ae[i] = sh_ctrl[i][8];   de[i] = sh_ctrl[2+i][8];
      ah[i] = ae[i] && m_addr(i, a, s);
      dh[i] = de[i] && m_data(2+i, a, s, d);
    end
    ev = ((ae | de) != 0) && ((ah | ~ae) == 2'b11) && ((dh | ~de) == 2'b11);
    exp_q.push_back({ev, ah, dh});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_valid = 1'b0;
    end
  endtask

  // monitor: compares each result one cycle after its access
  initial begin
    logic v;
    logic [4:0] e;
    string t;
    forever begin
      @(posedge clk);
      v = acc_valid && rst_n;
      @(negedge clk);
      if (v && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        if ({event_o, addr_hit_o, data_hit_o} !== e) begin
          n_fail++;
          $display("FAIL %s: got ev/ah/dh=%b expected %b", t, {event_o, addr_hit_o, data_hit_o}, e);
        end
      end else if (rst_n) begin
        n_tests++;
        if ({event_o, addr_hit_o, data_hit_o} !== 5'b0) begin
          n_fail++;
          $display("FAIL R8 idle: got %b expected 00000", {event_o, addr_hit_o, data_hit_o});
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin sh_ref[i] = '0; sh_ctrl[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_tests++;
    if ({event_o, addr_hit_o, data_hit_o} !== 5'b0) begin
      n_fail++;
      $display("FAIL R9 reset: got %b expected 00000", {event_o, addr_hit_o, data_hit_o});
    end

    // R7 / R9: all comparators disabled after reset, no event
    access(32'h0, 2'd2, 32'h0, "R7 none enabled");
    idle(1);

    // byte-lane range on address 3 (R4, R3, R1)
    wr(3'b000, 32'h3);         wr(3'b001, 32'h100);
    wr(3'b100, 32'h7);         wr(3'b101, 32'h1EA);
    wr(3'b110, 32'hC);         wr(3'b111, 32'h1EB);
    access(32'h3, 2'd0, 32'h0000_0009, "R4 byte access in range");
    idle(1);
    access(32'h0, 2'd2, 32'h0000_000A, "R4 word access covers lane3");
    access(32'h2, 2'd1, 32'h0000_000B, "R4 half access covers lane3");
    access(32'h3, 2'd0, 32'h0000_0007, "R4 low bound excluded");
    access(32'h0, 2'd2, 32'h0000_000C, "R4 high bound excluded");
    access(32'h0, 2'd2, 32'h0000_0920, "R3 masked lane decoy");
    access(32'h2, 2'd0, 32'h0000_0900, "R1 byte address not masked");
    idle(2);

    // half-word range (R5, R2)
    wr(3'b000, 32'h0);         wr(3'b001, 32'h102);
    wr(3'b010, 32'hC);         wr(3'b011, 32'h103);
    wr(3'b100, 32'h4E20_4E20); wr(3'b101, 32'h106);
    wr(3'b110, 32'h9C40_9C40); wr(3'b111, 32'h107);
    access(32'h4, 2'd2, 32'h0000_5000, "R5 word access low half");
    access(32'h0, 2'd2, 32'h0000_5000, "R2 address not above bound");
    access(32'hA, 2'd1, 32'h0000_6000, "R5 half access upper addr");
    access(32'h8, 2'd1, 32'h6000_0000, "R5 half access lower addr");
    access(32'h8, 2'd1, 32'h0000_6000, "R5 untransferred half decoy");
    access(32'h5, 2'd0, 32'h0060_0000, "R5 byte access never matches");
    access(32'h4, 2'd2, 32'h9C40_0000, "R5 upper bound excluded");
    idle(1);

    // word mode, not-equal, disabled partners (R6, R2, R7)
    wr(3'b011, 32'h0);         wr(3'b111, 32'h0);
    wr(3'b000, 32'h100);       wr(3'b001, 32'h101);
    wr(3'b100, 32'hDEAD_BEEF); wr(3'b101, 32'h110);
    access(32'h200, 2'd2, 32'hDEAD_BE00, "R6 word equal with lane3 masked");
    access(32'h100, 2'd2, 32'hDEAD_BEEF, "R2 not-equal address fails");
    access(32'h104, 2'd2, 32'hDEAD_BFEF, "R6 word mismatch");
    idle(1);

    // less-than / greater-than on address, back-to-back (R2, R8)
    wr(3'b101, 32'h0);
    wr(3'b000, 32'h1000);      wr(3'b001, 32'h103);
    access(32'h0FFC, 2'd2, 32'h0, "R8 back-to-back first");
    access(32'h1000, 2'd2, 32'h0, "R2 less-than boundary");
    access(32'h0FFF, 2'd0, 32'h0, "R8 back-to-back third");
    idle(2);
    wr(3'b000, 32'h1003);      wr(3'b001, 32'h102);
    access(32'h1003, 2'd0, 32'h0, "R2 greater-than equal value");
    access(32'h1004, 2'd2, 32'h0, "R2 greater-than above");
    idle(1);

    // size-dependent address masking (R1)
    wr(3'b000, 32'h2003);      wr(3'b001, 32'h100);
    access(32'h2000, 2'd2, 32'h0, "R1 word drops two bits");
    access(32'h2002, 2'd1, 32'h0, "R1 half drops one bit");
    access(32'h2002, 2'd0, 32'h0, "R1 byte keeps all bits");
    access(32'h2000, 2'd1, 32'h0, "R1 half wrong word half");
    idle(1);

    // R7: disable the last comparator, nothing enabled again
    wr(3'b001, 32'h0);
    access(32'h2003, 2'd0, 32'h0, "R7 all disabled after use");
    idle(3);

    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R8 scoreboard: got %0d pending expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule